// File: doc/BRIEF.md
# DMA Descriptor Chain Loader

This block is the chaining stage of one DMA channel. When the channel reports that its current block has finished, the loader looks at the channel's link pointer. If the pointer is zero, the chain is over and the loader raises the terminal-count event. If the pointer is nonzero, the loader reads an eight-word descriptor from memory through a simple request/response read port. Once it holds all eight words, it hands them to the channel registers in a single load cycle and then restarts the channel.

Every descriptor carries its own control word and its own next pointer. This lets the address modes change from one link to the next with no processor involvement. Descriptors must sit on 64-byte boundaries. Transfer sizes are counted in source-width units and are passed through unchanged. The address engine and the register bus sit outside this block and are reached only through the load strobe, the field outputs and the restart pulse.

Top module: `dma_desc_loader`

## Requirements
- R1: After reset the loader is idle: no read request, no load or restart strobe, no event output, and busy low.
- R2: A block-done pulse seen while idle with a link pointer of zero in all 64 bits raises tc_o for exactly one cycle, in the cycle after the pulse, and issues no read. tc_o is never raised when a further descriptor is fetched.
- R3: A block-done pulse with a nonzero pointer whose low six bits are not all zero raises err_o for one cycle and issues no read.
- R4: For an aligned nonzero pointer P, the loader issues exactly eight reads, in order, at P + 4k for k = 0..7. Only one read is outstanding at a time. While rd_ready_i is low, a request is held with a stable address.
- R5: The cycle after the eighth good response, load_o is high for exactly one cycle. At that point ctrl_o = word 0, xfer_size_o = word 1, src_addr_o = {word 3, word 2}, dst_addr_o = {word 5, word 4} and next_ptr_o = {word 7, word 6}. No load occurs before all eight words have arrived.
- R6: restart_o is high for exactly one cycle, in the cycle right after load_o.
- R7: A response with rsp_err_i high raises err_o for one cycle. No further read is issued, and neither load_o nor restart_o occurs for that chain.
- R8: abort_i during a fetch raises aborted_o for one cycle. No further read is issued, and neither load_o nor restart_o occurs.
- R9: If a read is still in flight when an abort is taken, busy_o stays high and no new request is made until that response has arrived. The next chain then loads only words from its own reads.
- R10: A block-done pulse that arrives while the loader is busy is ignored. The running chain keeps its original pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blk_done_i | input | 1 | Channel finished its current block |
| link_ptr_i | input | 64 | Channel's current link pointer |
| abort_i | input | 1 | Abort request |
| rd_req_o | output | 1 | Read request valid |
| rd_addr_o | output | 64 | Read byte address |
| rd_ready_i | input | 1 | Read request accepted |
| rsp_valid_i | input | 1 | Read response valid |
| rsp_data_i | input | 32 | Read response data |
| rsp_err_i | input | 1 | Read response error |
| load_o | output | 1 | Load strobe for all channel registers |
| ctrl_o | output | 32 | Control word for the next block |
| xfer_size_o | output | 32 | Transfer size, in source-width units |
| src_addr_o | output | 64 | Source address |
| dst_addr_o | output | 64 | Destination address |
| next_ptr_o | output | 64 | Next link pointer |
| restart_o | output | 1 | Channel restart pulse |
| tc_o | output | 1 | Terminal-count event (end of chain) |
| err_o | output | 1 | Error event |
| aborted_o | output | 1 | Abort-taken event |
| busy_o | output | 1 | Loader is active |

## Verification
The hardest case to reach is an abort that lands while a read is still in flight. The drain path only matters if the response arrives after the loader has already dropped the chain. The bench reaches this case by counting accepted requests. It raises abort right after the k-th acceptance, for every k, under a three-cycle response latency. It then checks that busy stays high and that a chain started straight afterwards loads only its own words. The same per-index sweep is used to place a read error on each of the eight descriptor words.

// File: rtl/dmal_pkg.sv
package dmal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_LOAD,
        ST_RESTART,
        ST_DRAIN
    } ldr_state_e;

endpackage

// File: rtl/dmal_ptr_check.sv
module dmal_ptr_check #(
    parameter int PTR_W       = 64,
    parameter int ALIGN_BYTES = 64,
    localparam int ALIGN_W    = $clog2(ALIGN_BYTES)
) (
    input  logic [PTR_W-1:0] ptr_i,
    output logic             is_zero_o,
    output logic             misaligned_o
);
    // The pointer is classified before any fetch is allowed.
    always_comb begin
        is_zero_o    = (ptr_i == '0);
        misaligned_o = |ptr_i[ALIGN_W-1:0];
    end
endmodule

// File: rtl/dmal_addr_gen.sv
module dmal_addr_gen #(
    parameter int PTR_W  = 64,
    parameter int WORD_W = 32,
    parameter int IDX_W  = 3,
    localparam int BYTE_SH = $clog2(WORD_W / 8)
) (
    input  logic [PTR_W-1:0] base_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [PTR_W-1:0] addr_o
);
    always_comb begin
        addr_o = base_i + (PTR_W'(idx_i) << BYTE_SH);
    end
endmodule

// File: rtl/dmal_word_store.sv
module dmal_word_store #(
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 8,
    localparam int IDX_W  = $clog2(N_WORDS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic [IDX_W-1:0]          wr_idx_i,
    input  logic [WORD_W-1:0]         wr_data_i,
    output logic [N_WORDS*WORD_W-1:0] words_o
);
    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        logic [WORD_W-1:0] word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
                word_d = wr_data_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else begin
                word_q <= word_d;
            end
        end

        assign words_o[g*WORD_W +: WORD_W] = word_q;
    end
endmodule

// File: rtl/dma_desc_loader.sv
module dma_desc_loader #(
    parameter int WORD_W      = 32,
    parameter int ALIGN_BYTES = 64,
    localparam int PTR_W      = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_done_i,
    input  logic [PTR_W-1:0]  link_ptr_i,
    input  logic              abort_i,
    output logic              rd_req_o,
    output logic [PTR_W-1:0]  rd_addr_o,
    input  logic              rd_ready_i,
    input  logic              rsp_valid_i,
    input  logic [WORD_W-1:0] rsp_data_i,
    input  logic              rsp_err_i,
    output logic              load_o,
    output logic [WORD_W-1:0] ctrl_o,
    output logic [WORD_W-1:0] xfer_size_o,
    output logic [PTR_W-1:0]  src_addr_o,
    output logic [PTR_W-1:0]  dst_addr_o,
    output logic [PTR_W-1:0]  next_ptr_o,
    output logic              restart_o,
    output logic              tc_o,
    output logic              err_o,
    output logic              aborted_o,
    output logic              busy_o
);
    import dmal_pkg::*;

    // The record layout is fixed at eight words; field slots below depend on it.
    localparam int N_WORDS            = 8;
    localparam int IDX_W              = $clog2(N_WORDS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_WORDS - 1);

    typedef struct packed {
        ldr_state_e       state;
        logic [IDX_W-1:0] idx;
        logic [PTR_W-1:0] base;
        logic             tc;
        logic             err;
        logic             abrt;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic                      ptr_zero, ptr_misal;
    logic                      wr_en;
    logic [N_WORDS*WORD_W-1:0] words;

    dmal_ptr_check #(
        .PTR_W       (PTR_W),
        .ALIGN_BYTES (ALIGN_BYTES)
    ) ptr_check_i (
        .ptr_i        (link_ptr_i),
        .is_zero_o    (ptr_zero),
        .misaligned_o (ptr_misal)
    );

    dmal_addr_gen #(
        .PTR_W  (PTR_W),
        .WORD_W (WORD_W),
        .IDX_W  (IDX_W)
    ) addr_gen_i (
        .base_i (ctx_q.base),
        .idx_i  (ctx_q.idx),
        .addr_o (rd_addr_o)
    );

    dmal_word_store #(
        .WORD_W  (WORD_W),
        .N_WORDS (N_WORDS)
    ) word_store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (ctx_q.idx),
        .wr_data_i (rsp_data_i),
        .words_o   (words)
    );

    always_comb begin
        ctx_d      = ctx_q;
        ctx_d.tc   = 1'b0;
        ctx_d.err  = 1'b0;
        ctx_d.abrt = 1'b0;
        wr_en      = 1'b0;

        unique case (ctx_q.state)
            ST_IDLE: begin
                if (blk_done_i) begin
                    if (ptr_zero) begin
                        ctx_d.tc = 1'b1;
                    end else if (ptr_misal) begin
                        ctx_d.err = 1'b1;
                    end else begin
                        ctx_d.base  = link_ptr_i;
                        ctx_d.idx   = '0;
                        ctx_d.state = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                if (abort_i) begin
                    ctx_d.abrt  = 1'b1;
                    // A request accepted in the same cycle still owes a response.
                    ctx_d.state = rd_ready_i ? ST_DRAIN : ST_IDLE;
                end else if (rd_ready_i) begin
                    ctx_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (abort_i) begin
                    ctx_d.abrt  = 1'b1;
                    ctx_d.state = rsp_valid_i ? ST_IDLE : ST_DRAIN;
                end else if (rsp_valid_i) begin
                    if (rsp_err_i) begin
                        ctx_d.err   = 1'b1;
                        ctx_d.state = ST_IDLE;
                    end else begin
                        wr_en = 1'b1;
                        if (ctx_q.idx == LAST) begin
                            ctx_d.state = ST_LOAD;
                        end else begin
                            ctx_d.idx   = ctx_q.idx + 1'b1;
                            ctx_d.state = ST_REQ;
                        end
                    end
                end
            end
            ST_LOAD: begin
                ctx_d.state = ST_RESTART;
            end
            ST_RESTART: begin
                ctx_d.state = ST_IDLE;
            end
            ST_DRAIN: begin
                if (rsp_valid_i) begin
                    ctx_d.state = ST_IDLE;
                end
            end
            default: begin
                ctx_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{state: ST_IDLE, idx: '0, base: '0, tc: 1'b0, err: 1'b0, abrt: 1'b0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    always_comb begin
        rd_req_o    = (ctx_q.state == ST_REQ);
        load_o      = (ctx_q.state == ST_LOAD);
        restart_o   = (ctx_q.state == ST_RESTART);
        busy_o      = (ctx_q.state != ST_IDLE);
        tc_o        = ctx_q.tc;
        err_o       = ctx_q.err;
        aborted_o   = ctx_q.abrt;
        ctrl_o      = words[0*WORD_W +: WORD_W];
        xfer_size_o = words[1*WORD_W +: WORD_W];
        src_addr_o  = {words[3*WORD_W +: WORD_W], words[2*WORD_W +: WORD_W]};
        dst_addr_o  = {words[5*WORD_W +: WORD_W], words[4*WORD_W +: WORD_W]};
        next_ptr_o  = {words[7*WORD_W +: WORD_W], words[6*WORD_W +: WORD_W]};
    end
endmodule

// File: rtl/dma_desc_loader_chk.sv
module dma_desc_loader_chk #(
    parameter int PTR_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             blk_done_i,
    input logic [PTR_W-1:0] link_ptr_i,
    input logic             abort_i,
    input logic             rd_req_o,
    input logic [PTR_W-1:0] rd_addr_o,
    input logic             rd_ready_i,
    input logic             load_o,
    input logic             restart_o,
    input logic             tc_o,
    input logic             err_o,
    input logic             busy_o
);
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ready_i && !abort_i) |=> (rd_req_o && $stable(rd_addr_o)));

    assert_restart_after_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> restart_o);

    assert_load_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);

    assert_tc_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tc_o |-> ($past(blk_done_i) && ($past(link_ptr_i) == '0)));

    assert_err_no_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !rd_req_o);

    assert_abort_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && (rd_req_o || (busy_o && !load_o && !restart_o))) |=> (!load_o && !rd_req_o));

    assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_req_o, load_o, restart_o}));
endmodule

bind dma_desc_loader dma_desc_loader_chk #(.PTR_W(PTR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .blk_done_i (blk_done_i),
    .link_ptr_i (link_ptr_i),
    .abort_i    (abort_i),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_ready_i (rd_ready_i),
    .load_o     (load_o),
    .restart_o  (restart_o),
    .tc_o       (tc_o),
    .err_o      (err_o),
    .busy_o     (busy_o)
);

// File: tb/dma_desc_loader_tb.sv
`timescale 1ns/1ps
module dma_desc_loader_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        blk_done_i = 1'b0;
    logic [63:0] link_ptr_i = '0;
    logic        abort_i = 1'b0;
    logic        rd_req_o;
    logic [63:0] rd_addr_o;
    logic        rd_ready_i = 1'b1;
    logic        rsp_valid_i = 1'b0;
    logic [31:0] rsp_data_i = '0;
    logic        rsp_err_i = 1'b0;
    logic        load_o, restart_o, tc_o, err_o, aborted_o, busy_o;
    logic [31:0] ctrl_o, xfer_size_o;
    logic [63:0] src_addr_o, dst_addr_o, next_ptr_o;

    always #2.5 clk = ~clk;

    dma_desc_loader dut_i (
        .clk(clk), .rst_n(rst_n), .blk_done_i(blk_done_i), .link_ptr_i(link_ptr_i),
        .abort_i(abort_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_ready_i(rd_ready_i), .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i),
        .rsp_err_i(rsp_err_i), .load_o(load_o), .ctrl_o(ctrl_o), .xfer_size_o(xfer_size_o),
        .src_addr_o(src_addr_o), .dst_addr_o(dst_addr_o), .next_ptr_o(next_ptr_o),
        .restart_o(restart_o), .tc_o(tc_o), .err_o(err_o), .aborted_o(aborted_o),
        .busy_o(busy_o)
    );

    int n_chk = 0, n_fail = 0;
    int n_req, n_load, n_rst, n_tc, n_err, n_abt;
    bit restart_bad, prev_load, stall, pend;
    int lat, cnt, cyc;
    logic [63:0] paddr, err_addr;
    logic [63:0] req_log [16];
    logic [31:0] cap_ctrl, cap_size;
    logic [63:0] cap_src, cap_dst, cap_nptr;

    function automatic logic [31:0] memf(input logic [63:0] a);
        return (a[31:0] * 32'h0100_0193) ^ a[63:32] ^ 32'hC3A5_0F1E;
    endfunction

    // Memory model and event monitor.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        rd_ready_i <= !stall || cyc[0];
        rsp_valid_i <= 1'b0;
        if (pend) begin
            if (cnt == 0) begin
                rsp_valid_i <= 1'b1;
                rsp_data_i  <= memf(paddr);
                rsp_err_i   <= (paddr == err_addr);
                pend        <= 1'b0;
            end else begin
                cnt <= cnt - 1;
            end
        end
        if (rst_n && rd_req_o && rd_ready_i) begin
            pend  <= 1'b1;
            paddr <= rd_addr_o;
            cnt   <= lat;
            if (n_req < 16) req_log[n_req] = rd_addr_o;
            n_req++;
        end
        if (rst_n) begin
            if (prev_load && !restart_o) restart_bad = 1'b1;
            if (restart_o && !prev_load) restart_bad = 1'b1;
            if (load_o) begin
                n_load++;
                cap_ctrl = ctrl_o; cap_size = xfer_size_o;
                cap_src = src_addr_o; cap_dst = dst_addr_o; cap_nptr = next_ptr_o;
            end
            if (restart_o) n_rst++;
            if (tc_o) n_tc++;
            if (err_o) n_err++;
            if (aborted_o) n_abt++;
            prev_load = load_o;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr();
        n_req = 0; n_load = 0; n_rst = 0; n_tc = 0; n_err = 0; n_abt = 0;
        restart_bad = 1'b0;
    endtask

    task automatic start(input logic [63:0] p);
        @(negedge clk);
        link_ptr_i = p; blk_done_i = 1'b1;
        @(negedge clk);
        blk_done_i = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!busy_o && !pend && !rsp_valid_i) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic verify_chain(input logic [63:0] b, input string tag);
        bit aok = 1'b1;
        chk(n_req == 8, {tag, " R4 read count"}, 64'(n_req), 64'd8);
        for (int k = 0; k < 8; k++) if (req_log[k] != b + 64'(4*k)) aok = 1'b0;
        chk(aok, {tag, " R4 read address order"}, req_log[0], b);
        chk(n_load == 1, {tag, " R5 single load"}, 64'(n_load), 64'd1);
        chk(cap_ctrl == memf(b) && cap_size == memf(b + 4), {tag, " R5 ctrl/size"},
            {cap_ctrl, cap_size}, {memf(b), memf(b + 4)});
        chk(cap_src == {memf(b + 12), memf(b + 8)}, {tag, " R5 source"}, cap_src,
            {memf(b + 12), memf(b + 8)});
        chk(cap_dst == {memf(b + 20), memf(b + 16)}, {tag, " R5 destination"}, cap_dst,
            {memf(b + 20), memf(b + 16)});
        chk(cap_nptr == {memf(b + 28), memf(b + 24)}, {tag, " R5 next pointer"}, cap_nptr,
            {memf(b + 28), memf(b + 24)});
        chk(n_rst == 1 && !restart_bad, {tag, " R6 restart after load"}, 64'(n_rst), 64'd1);
        chk(n_tc == 0 && n_err == 0, {tag, " R2 no tc mid chain"}, 64'(n_tc + n_err), 64'd0);
    endtask

    logic [63:0] bases [8] = '{64'h0000_0000_0000_0040, 64'h0000_0000_0000_1000,
                               64'h0000_0000_FFFF_FFC0, 64'h0000_0001_0000_0000,
                               64'h0000_0000_8000_03C0, 64'h1234_5678_9ABC_DE00,
                               64'h0000_0000_0000_7F80, 64'hFFFF_FFFF_FFFF_FF80};

    initial begin
        clr(); stall = 0; lat = 0; cnt = 0; cyc = 0; pend = 0; prev_load = 0;
        err_addr = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rd_req_o && !load_o && !restart_o && !tc_o && !err_o && !aborted_o && !busy_o,
            "R1 reset idle", {58'd0, rd_req_o, load_o, restart_o, tc_o, err_o, busy_o}, 64'd0);

        // Chains over many bases, latencies and request stalls.
        for (int l = 0; l < 3; l++) begin
            for (int s = 0; s < 2; s++) begin
                for (int b = 0; b < 8; b++) begin
                    lat = l; stall = s[0];
                    clr(); start(bases[b]); wait_idle();
                    verify_chain(bases[b], "chain");
                end
            end
        end
        stall = 0; lat = 0;

        // End of chain.
        clr(); start(64'd0); wait_idle();
        chk(n_tc == 1, "R2 tc on zero pointer", 64'(n_tc), 64'd1);
        chk(n_req == 0 && n_load == 0, "R2 no read on zero pointer", 64'(n_req), 64'd0);

        // Every misaligned low-bit pattern.
        for (int m = 1; m < 64; m++) begin
            clr(); start(64'h0000_0000_0000_2000 | 64'(m)); wait_idle();
            chk(n_err == 1 && n_req == 0 && n_load == 0 && n_tc == 0, "R3 misaligned pointer",
                {32'(n_err), 32'(n_req)}, {32'd1, 32'd0});
        end

        // Read error on each descriptor word.
        for (int k = 0; k < 8; k++) begin
            err_addr = 64'h0000_0000_0000_0300 + 64'(4*k);
            clr(); start(64'h0000_0000_0000_0300); wait_idle();
            chk(n_err == 1 && n_req == k + 1, "R7 error response stops fetch",
                {32'(n_err), 32'(n_req)}, {32'd1, 32'(k + 1)});
            chk(n_load == 0 && n_rst == 0, "R7 no load after error", 64'(n_load + n_rst), 64'd0);
        end
        err_addr = '1;

        // Abort after each accepted read, with short and long latency.
        for (int l = 0; l < 4; l += 3) begin
            for (int k = 0; k < 8; k++) begin
                lat = l;
                clr(); start(64'h0000_0000_0000_0500);
                for (int i = 0; i < 200; i++) begin
                    if (n_req == k + 1) break;
                    @(negedge clk);
                end
                abort_i = 1'b1;
                @(negedge clk);
                abort_i = 1'b0;
                if (l == 3) begin
                    chk(busy_o && !rd_req_o, "R9 drain holds busy", {62'd0, busy_o, rd_req_o},
                        64'd2);
                end
                wait_idle();
                chk(n_abt == 1 && n_req == k + 1, "R8 abort stops fetch",
                    {32'(n_abt), 32'(n_req)}, {32'd1, 32'(k + 1)});
                chk(n_load == 0 && n_rst == 0, "R8 no load after abort", 64'(n_load + n_rst),
                    64'd0);
                clr(); start(64'h0000_0000_0000_0A40); wait_idle();
                verify_chain(64'h0000_0000_0000_0A40, "R9 chain after abort");
            end
        end
        lat = 0;

        // Block-done while busy.
        lat = 2;
        clr(); start(64'h0000_0000_0000_0C00);
        repeat (3) @(negedge clk);
        start(64'h0000_0000_0000_0E00);
        wait_idle();
        verify_chain(64'h0000_0000_0000_0C00, "R10 busy blk_done ignored");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #750000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule